// File: doc/BRIEF.md
# PHY Bring-Up Sequencer

This block brings an attached gigabit Ethernet PHY into service after power-up, with no software involved. The first request starts a timed reset of the PHY. The block then issues a fixed, ordered list of register writes through the request/acknowledge port of an MDIO master. The list holds five vendor debug patches, each written as a debug-address and debug-data pair, then the link-change interrupt enable, the autonegotiation advertisement for the chosen media type, the 1000BASE-T control word where the PHY supports gigabit, and finally a combined reset and autonegotiation restart command.

Only one MDIO transfer is outstanding at a time. An acknowledge that returns with the error flag set stops the sequence at once and raises `error`. After a clean run the block is marked configured. Any later request writes the stored advertisement words again and then the restart command. It skips the reset pulse and the patches.

All delays are counted in clock cycles and derived from the `CLK_HZ` parameter.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `mdio_req` are all 0, and `phy_rst_n` is 0, meaning the PHY is held in reset.
- R2: On a first request, `phy_rst_n` stays low for 2 ms (between 2 ms and 2 ms + 3 cycles) and then goes high. The first MDIO request comes at least 2 ms after that release, and never while `phy_rst_n` is low.
- R3: The first ten writes are the debug pairs in this order: (0x0B, 0xBC00), (0x00, 0x02EF), (0x12, 0x4C04), (0x04, 0x8BBB), (0x05, 0x2C46). In each pair the address goes to PHY register 0x1D and the data goes to register 0x1E.
- R4: After the last patch, `mdio_req` stays low for at least 1 ms and at most 1 ms + 3 cycles. The next write is 0x0C00 to register 0x12.
- R5: Register 4 is written with 0x0C01 (selector 00001, bit 10 symmetric pause, bit 11 asymmetric pause) ORed with speed bits chosen by `media_sel`:
  - 0 (auto-sense): bits 8:5 all set, 0x0DE1
  - 1 (100 full): bit 8, 0x0D01
  - 2 (100 half): bit 7, 0x0C81
  - 3 (10 full): bit 6, 0x0C41
  - 4 to 7: bit 5 (10 half), 0x0C21
- R6: Register 9 is written only when `phy_kind` is 0 (full gigabit) or 1 (gigabit-capable). It is 0x0200 (1000 full) only when `phy_kind` is 0 and `media_sel` is 0, and 0x0000 otherwise. For `phy_kind` 2 or 3 it is not written.
- R7: The last write is 0x9200 to register 0. This value sets bit 15 (reset), bit 12 (autoneg enable) and bit 9 (restart). `done` rises once that write is acknowledged without error.
- R8: An acknowledge with `mdio_err` set ends the sequence. No further request follows, `error` is 1 and `done` is 0. The block is no longer configured, so the next request repeats the full bring-up.
- R9: Once configured, a request writes only register 4, then register 9 (if applicable), then register 0. It uses the words stored at the first bring-up, ignores the current `media_sel` and `phy_kind`, and leaves `phy_rst_n` high.
- R10: While `mdio_req` is high and not yet acknowledged, the request and its `mdio_reg` and `mdio_wdata` stay unchanged.
- R11: A `start` pulse while `busy` is high is ignored and does not change the running write list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a bring-up (or a restart once configured) |
| media_sel | input | 3 | Media type used for the advertisement |
| phy_kind | input | 2 | 0 full gigabit, 1 gigabit-capable, 2/3 fast Ethernet only |
| phy_rst_n | output | 1 | Active-low PHY reset control |
| mdio_req | output | 1 | MDIO write request, held until acknowledged |
| mdio_reg | output | 5 | PHY register address of the request |
| mdio_wdata | output | 16 | Data of the request |
| mdio_ack | input | 1 | Transfer finished (one cycle) |
| mdio_err | input | 1 | Transfer failed, valid with `mdio_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence finished cleanly |
| error | output | 1 | Last sequence aborted on an MDIO error |

## Verification
The assertions check these properties on every cycle:
- the request is stable until acknowledged;
- no MDIO traffic occurs while the PHY is held in reset;
- nothing follows an errored acknowledge;
- `done` rises only after the control-register write;
- a restart leaves the PHY reset released.

Other properties can only be shown by the bench's scenarios. These are the exact contents and order of the write list, the advertisement and gigabit words for every media type and PHY kind, the lengths of the reset and pause windows, and the abort at each possible position. They also include the shortened list after configuration, using the stored words, and the ignored request during a busy run.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST_HOLD,
    S_RST_WAIT,
    S_WRITE,
    S_PAUSE
  } seq_state_t;

  localparam logic [4:0] REG_BMCR = 5'h00;
  localparam logic [4:0] REG_ADV  = 5'h04;
  localparam logic [4:0] REG_GIG  = 5'h09;
  localparam logic [4:0] REG_INTC = 5'h12;
  localparam logic [4:0] REG_DBGA = 5'h1D;
  localparam logic [4:0] REG_DBGD = 5'h1E;

  localparam logic [3:0] STEP_FIRST      = 4'd0;
  localparam logic [3:0] STEP_LAST_PATCH = 4'd9;
  localparam logic [3:0] STEP_INTC       = 4'd10;
  localparam logic [3:0] STEP_ADV        = 4'd11;
  localparam logic [3:0] STEP_GIG        = 4'd12;
  localparam logic [3:0] STEP_CMD        = 4'd13;

  localparam logic [15:0] CMD_RESTART = 16'h9200;
  localparam logic [15:0] INTC_VALUE  = 16'h0C00;
  localparam logic [15:0] ADV_BASE    = 16'h0C01;
  localparam logic [15:0] GIG_1000FD  = 16'h0200;

endpackage

// File: rtl/physeq_timer.sv
module physeq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/physeq_adv.sv
module physeq_adv
  import physeq_pkg::*;
(
  input  logic [2:0]  media_sel,
  input  logic [1:0]  phy_kind,
  output logic [15:0] adv_word,
  output logic [15:0] gig_word,
  output logic        gig_write
);
  logic [15:0] speed_bits;

  always_comb begin
    case (media_sel)
      3'd0:    speed_bits = 16'h01E0;
      3'd1:    speed_bits = 16'h0100;
      3'd2:    speed_bits = 16'h0080;
      3'd3:    speed_bits = 16'h0040;
      default: speed_bits = 16'h0020;
    endcase
  end

  assign adv_word  = ADV_BASE | speed_bits;
  assign gig_write = ~phy_kind[1];
  assign gig_word  = ((media_sel == 3'd0) && (phy_kind == 2'd0)) ? GIG_1000FD : 16'h0000;
endmodule

// File: rtl/physeq_steps.sv
module physeq_steps
  import physeq_pkg::*;
(
  input  logic [3:0]  step,
  input  logic [15:0] adv_word,
  input  logic [15:0] gig_word,
  output logic [4:0]  wr_reg,
  output logic [15:0] wr_data
);
  always_comb begin
    wr_reg  = REG_BMCR;
    wr_data = CMD_RESTART;
    case (step)
      4'd0:  begin wr_reg = REG_DBGA; wr_data = 16'h000B; end
      4'd1:  begin wr_reg = REG_DBGD; wr_data = 16'hBC00; end
      4'd2:  begin wr_reg = REG_DBGA; wr_data = 16'h0000; end
      4'd3:  begin wr_reg = REG_DBGD; wr_data = 16'h02EF; end
      4'd4:  begin wr_reg = REG_DBGA; wr_data = 16'h0012; end
      4'd5:  begin wr_reg = REG_DBGD; wr_data = 16'h4C04; end
      4'd6:  begin wr_reg = REG_DBGA; wr_data = 16'h0004; end
      4'd7:  begin wr_reg = REG_DBGD; wr_data = 16'h8BBB; end
      4'd8:  begin wr_reg = REG_DBGA; wr_data = 16'h0005; end
      4'd9:  begin wr_reg = REG_DBGD; wr_data = 16'h2C46; end
      4'd10: begin wr_reg = REG_INTC; wr_data = INTC_VALUE; end
      4'd11: begin wr_reg = REG_ADV;  wr_data = adv_word; end
      4'd12: begin wr_reg = REG_GIG;  wr_data = gig_word; end
      default: begin wr_reg = REG_BMCR; wr_data = CMD_RESTART; end
    endcase
  end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import physeq_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  media_sel,
  input  logic [1:0]  phy_kind,
  output logic        phy_rst_n,
  output logic        mdio_req,
  output logic [4:0]  mdio_reg,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_ack,
  input  logic        mdio_err,
  output logic        busy,
  output logic        done,
  output logic        error
);
  localparam int MS_CYC = CLK_HZ / 1000;
  localparam int T2_CYC = 2 * MS_CYC;
  localparam int TW     = $clog2(T2_CYC + 1);

  seq_state_t  state_q, state_d;
  logic [3:0]  step_q, step_d;
  logic [15:0] adv_q, adv_d, gig_q, gig_d;
  logic        gigwr_q, gigwr_d;
  logic        cfg_q, cfg_d;
  logic        done_q, done_d, err_q, err_d;
  logic        prst_q, prst_d;
  logic        tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic [15:0] adv_new, gig_new;
  logic        gigwr_new;

  physeq_adv i_adv (
    .media_sel (media_sel),
    .phy_kind  (phy_kind),
    .adv_word  (adv_new),
    .gig_word  (gig_new),
    .gig_write (gigwr_new)
  );

  physeq_timer #(.W(TW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  physeq_steps i_steps (
    .step     (step_q),
    .adv_word (adv_q),
    .gig_word (gig_q),
    .wr_reg   (mdio_reg),
    .wr_data  (mdio_wdata)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    adv_d    = adv_q;
    gig_d    = gig_q;
    gigwr_d  = gigwr_q;
    cfg_d    = cfg_q;
    done_d   = done_q;
    err_d    = err_q;
    prst_d   = prst_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      S_IDLE: if (start) begin
        done_d = 1'b0;
        err_d  = 1'b0;
        if (cfg_q) begin
          step_d  = STEP_ADV;
          state_d = S_WRITE;
        end else begin
          adv_d    = adv_new;
          gig_d    = gig_new;
          gigwr_d  = gigwr_new;
          prst_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TW'(T2_CYC);
          state_d  = S_RST_HOLD;
        end
      end
      S_RST_HOLD: if (tmr_exp) begin
        prst_d   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(T2_CYC);
        state_d  = S_RST_WAIT;
      end
      S_RST_WAIT: if (tmr_exp) begin
        step_d  = STEP_FIRST;
        state_d = S_WRITE;
      end
      S_WRITE: if (mdio_ack) begin
        if (mdio_err) begin
          err_d   = 1'b1;
          cfg_d   = 1'b0;
          state_d = S_IDLE;
        end else begin
          case (step_q)
            STEP_LAST_PATCH: begin
              step_d   = STEP_INTC;
              tmr_load = 1'b1;
              tmr_val  = TW'(MS_CYC);
              state_d  = S_PAUSE;
            end
            STEP_ADV: step_d = gigwr_q ? STEP_GIG : STEP_CMD;
            STEP_CMD: begin
              done_d  = 1'b1;
              cfg_d   = 1'b1;
              state_d = S_IDLE;
            end
            default: step_d = step_q + 4'd1;
          endcase
        end
      end
      S_PAUSE: if (tmr_exp) state_d = S_WRITE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      adv_q   <= '0;
      gig_q   <= '0;
      gigwr_q <= 1'b0;
      cfg_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      prst_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      adv_q   <= adv_d;
      gig_q   <= gig_d;
      gigwr_q <= gigwr_d;
      cfg_q   <= cfg_d;
      done_q  <= done_d;
      err_q   <= err_d;
      prst_q  <= prst_d;
    end
  end

  assign mdio_req  = (state_q == S_WRITE);
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign phy_rst_n = prst_q;

  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && !mdio_ack |=> mdio_req && $stable(mdio_reg) && $stable(mdio_wdata));

  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rst_n |-> !mdio_req);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && mdio_ack && mdio_err |=> !mdio_req && error && !done);

  a_r7_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mdio_ack) && ($past(mdio_reg) == REG_BMCR));

  a_r9_restart_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && cfg_q |=> phy_rst_n);
endmodule

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;
  localparam int CLK_HZ = 500_000;
  localparam int MS = CLK_HZ / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] media_sel = 3'd0;
  logic [1:0] phy_kind = 2'd0;
  logic phy_rst_n, mdio_req, busy, done, error;
  logic [4:0] mdio_reg;
  logic [15:0] mdio_wdata;
  logic ack_r = 1'b0, err_r = 1'b0;

  always #2 clk = ~clk;

  phy_bringup_seq #(.CLK_HZ(CLK_HZ)) i_phy_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .media_sel(media_sel),
    .phy_kind(phy_kind), .phy_rst_n(phy_rst_n), .mdio_req(mdio_req),
    .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_ack(ack_r),
    .mdio_err(err_r), .busy(busy), .done(done), .error(error)
  );

  int total = 0, bad = 0;
  logic [4:0]  l_reg [16];
  logic [15:0] l_dat [16];
  int log_n = 0, fail_at = -1, lat = 0, unstable = 0;
  int rst_low = 0, rel_cnt = 0, gap = 0;
  bit held = 0;
  logic [4:0] h_reg;
  logic [15:0] h_dat;
  logic [4:0]  e_reg [16];
  logic [15:0] e_dat [16];
  int e_n = 0;

  // MDIO master model and window counters
  always @(negedge clk) begin
    if (busy && !phy_rst_n) rst_low++;
    if (busy && phy_rst_n && log_n == 0 && !mdio_req) rel_cnt++;
    if (busy && log_n == 10 && !mdio_req && !ack_r) gap++;
    if (!rst_n) begin
      ack_r = 0; err_r = 0; held = 0;
    end else if (ack_r) begin
      ack_r = 0; err_r = 0; held = 0; lat = $urandom_range(0, 3);
    end else if (mdio_req) begin
      if (held && (mdio_reg != h_reg || mdio_wdata != h_dat)) unstable++;
      held = 1; h_reg = mdio_reg; h_dat = mdio_wdata;
      if (lat == 0) begin
        if (log_n < 16) begin l_reg[log_n] = mdio_reg; l_dat[log_n] = mdio_wdata; end
        err_r = (log_n == fail_at);
        log_n++;
        ack_r = 1;
      end else lat--;
    end
  end

  function automatic logic [15:0] exp_adv(int m);
    case (m)
      0: return 16'h0DE1;
      1: return 16'h0D01;
      2: return 16'h0C81;
      3: return 16'h0C41;
      default: return 16'h0C21;
    endcase
  endfunction

  function automatic logic [15:0] exp_gig(int m, int k);
    return (m == 0 && k == 0) ? 16'h0200 : 16'h0000;
  endfunction

  task automatic push(logic [4:0] r, logic [15:0] d);
    e_reg[e_n] = r; e_dat[e_n] = d; e_n++;
  endtask

  task automatic build_exp(bit full, int m, int k);
    logic [15:0] pa [5];
    logic [15:0] pd [5];
    pa = '{16'h000B, 16'h0000, 16'h0012, 16'h0004, 16'h0005};
    pd = '{16'hBC00, 16'h02EF, 16'h4C04, 16'h8BBB, 16'h2C46};
    e_n = 0;
    if (full) begin
      for (int i = 0; i < 5; i++) begin
        push(5'h1D, pa[i]);
        push(5'h1E, pd[i]);
      end
      push(5'h12, 16'h0C00);
    end
    push(5'h04, exp_adv(m));
    if (k < 2) push(5'h09, exp_gig(m, k));
    push(5'h00, 16'h9200);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_log(string req);
    bit ok = (log_n == e_n);
    int at = -1;
    for (int i = 0; i < e_n && i < log_n && i < 16; i++)
      if (ok && (l_reg[i] != e_reg[i] || l_dat[i] != e_dat[i])) begin ok = 0; at = i; end
    if (at >= 0) chk(0, req, {11'd0, l_reg[at], l_dat[at]}, {11'd0, e_reg[at], e_dat[at]});
    else chk(ok, req, log_n, e_n);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run(int m, int k, bit mid_start);
    log_n = 0; rst_low = 0; rel_cnt = 0; gap = 0;
    @(negedge clk);
    media_sel = 3'(m); phy_kind = 2'(k); start = 1;
    @(negedge clk);
    start = 0;
    if (mid_start) begin
      repeat (50) @(negedge clk);
      media_sel = 3'((m + 1) % 5); phy_kind = 2'((k + 1) % 4); start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic full_case(int m, int k);
    do_reset();
    run(m, k, 0);
    build_exp(1, m, k);
    check_log("R3 R5 R6 R7 write list");
    chk(done && !error, "R7 done", {done, error}, 2'b10);
    chk(rst_low >= 2 * MS && rst_low <= 2 * MS + 3, "R2 reset hold", rst_low, 2 * MS);
    chk(rel_cnt >= 2 * MS, "R2 release wait", rel_cnt, 2 * MS);
    chk(gap >= MS && gap <= MS + 3, "R4 pause", gap, MS);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    chk(!busy && !done && !error && !mdio_req && !phy_rst_n, "R1 reset state",
        {busy, done, error, mdio_req, phy_rst_n}, 0);

    // directed media/kind corners: R5, R6
    full_case(0, 0);
    full_case(0, 1);
    full_case(1, 0);
    full_case(2, 2);
    full_case(3, 1);
    full_case(6, 3);

    // R9: restart uses stored words even if inputs change
    full_case(0, 0);
    run(3, 3, 0);
    build_exp(0, 0, 0);
    check_log("R9 restart list");
    chk(rst_low == 0 && phy_rst_n, "R9 no reset pulse", rst_low, 0);
    chk(done && !error, "R9 done", {done, error}, 2'b10);

    // R8: abort at several positions, then full redo
    for (int p = 0; p < 14; p += 3) begin
      do_reset();
      fail_at = p;
      run(1, 0, 0);
      fail_at = -1;
      chk(error && !done, "R8 error flag", {error, done}, 2'b10);
      chk(log_n == p + 1, "R8 stop after failure", log_n, p + 1);
      run(1, 0, 0);
      build_exp(1, 1, 0);
      check_log("R8 full redo after error");
    end

    // R8 abort during restart clears configured state
    full_case(2, 1);
    fail_at = 1;
    run(2, 1, 0);
    fail_at = -1;
    chk(error && log_n == 2, "R8 restart abort", log_n, 2);
    run(2, 1, 0);
    build_exp(1, 2, 1);
    check_log("R8 full redo after restart error");

    // R11: start while busy ignored
    do_reset();
    run(3, 0, 1);
    build_exp(1, 3, 0);
    check_log("R11 busy start ignored");

    // random mix
    for (int n = 0; n < 8; n++) begin
      int m = $urandom_range(0, 7);
      int k = $urandom_range(0, 3);
      full_case(m, k);
      run($urandom_range(0, 7), $urandom_range(0, 3), 0);
      build_exp(0, m, k);
      check_log("R9 random restart");
    end

    chk(unstable == 0, "R10 request stable", unstable, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule